// File: doc/BRIEF.md
# Scan and Conversion Pacing Sequencer

This block paces a multichannel acquisition. Two programmable interval timers set the timing. Each timer chains a base-tick counter, a 4-bit prescaler and a 16-bit divider. The conversion timer sets the spacing between conversions inside a scan. The scan timer sets the spacing between scan starts. A channel list memory holds one 8-bit entry per conversion, with the gain select in the upper two bits and the channel number in the lower six. When a scan begins, the sequencer walks the list from entry 0 and emits one conversion strobe per conversion tick, carrying the entry's channel and gain. It stops after the programmed scan length and marks the last strobe with a scan-done pulse.

Software-side logic writes seven configuration words through a small write port and fills the list through a second write port. It then pulses `start`. The trigger mode decides what happens next:
- a single scan at once;
- a single scan on an external trigger;
- scans retriggered by the scan timer, started either at once or by an external trigger;
- one scan per external trigger.

A scan request that arrives while a scan is still converting is dropped, and a sticky overrun flag is set.

The controller has four states:
- IDLE: waits for `start`.
- ARMED: waits for `ext_trig`.
- CONVERT: issues strobes.
- GAP: a repeating scan has finished and the controller waits for the next scan tick.

The transitions are:
- start: IDLE or any other state goes to CONVERT, or to ARMED in the external modes.
- trigger: ARMED goes to CONVERT.
- scan end: CONVERT goes to GAP in the repeating modes, to ARMED in the per-trigger mode, and to IDLE otherwise.
- rescan: GAP goes to CONVERT on a scan tick.
- abort: any state goes to IDLE on `stop`.

Top module: `acq_pacer`

## Requirements
- R1: After reset `conv_strobe`, `scan_done`, `overrun`, `conv_chan` and `conv_gain` are all 0, and no strobe appears until `start`.
- R2: The conversion period in clock cycles is CONV_BASE_CYC × (prescale + 1) × divider. The prescale is config word 1 (bits 3:0) and the divider is config word 2. A divider of 0 counts as 65536. Within a scan, strobe k appears k × period cycles after the first strobe.
- R3: The scan period in clock cycles is SCAN_BASE_CYC × (prescale + 1) × divider. The prescale is config word 3 (bits 3:0) and the divider is config word 4. A divider of 0 counts as 65536. The scan timer is loaded when a repeating run begins.
- R4: A scan's first strobe appears in the clock cycle after the cycle in which the scan begins. Strobe k carries list entry k: `conv_gain` = entry bits 7:6 and `conv_chan` = entry bits 5:0.
- R5: The scan length is config word 0. A value of 0 acts as 1, and a value above LIST_DEPTH (512) acts as 512. Exactly that many strobes occur per scan, and `scan_done` is high together with the last strobe only.
- R6: The trigger mode is config word 5, bits 4:2. Value 0 makes `start` run one scan and then return to idle. The unused values 5, 6 and 7 behave like value 0.
- R7: With mode 2, `start` begins a scan at once and a new scan begins on every scan tick after it.
- R8: With mode 1, `start` arms the controller and the next `ext_trig` runs one scan. With mode 3, the next `ext_trig` begins a scan and loads the scan timer, and scans then repeat on every scan tick.
- R9: With mode 4, every `ext_trig` while armed runs one scan, after which the controller is armed again. An `ext_trig` during a scan sets `overrun` and does not restart the scan.
- R10: In modes 2 and 3, a scan tick that arrives while a scan is converting sets `overrun` in the following cycle. The running scan completes unchanged, and that tick starts no scan. `overrun` stays set until the next `start`.
- R11: `stop` returns the controller to idle. No strobe and no `scan_done` follow it.
- R12: `conv_diff` follows config word 6, bit 0, where 1 means differential input.
- R13: `ext_trig` while idle, or after a one-shot scan has ended, produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_addr | input | 3 | Configuration word index (0 length, 1/2 conversion prescale/divider, 3/4 scan prescale/divider, 5 mode, 6 input type) |
| cfg_wdata | input | 16 | Configuration write data |
| list_we | input | 1 | Channel list write enable |
| list_addr | input | 9 | Channel list entry index |
| list_wdata | input | 8 | Entry: gain in 7:6, channel in 5:0 |
| start | input | 1 | Begin a run according to the mode; clears overrun |
| stop | input | 1 | Abort and return to idle |
| ext_trig | input | 1 | External trigger pulse |
| conv_strobe | output | 1 | One-cycle conversion request |
| conv_chan | output | 6 | Channel of the current conversion |
| conv_gain | output | 2 | Gain select of the current conversion |
| conv_diff | output | 1 | Differential input selected |
| scan_done | output | 1 | High with the last strobe of a scan |
| overrun | output | 1 | Sticky: a scan request arrived during a scan |

## Verification
A corrupted entry index shows up as a wrong channel or gain on the very next strobe. It also moves `scan_done` off the last strobe within one scan. Timer counter faults shift strobe cycles. The bench compares every strobe's cycle number against the period formula, so a fault of a single cycle is reported at the first strobe it affects. State register faults appear as missing or extra strobes, or as a missing overrun, within one scan period. The bench checks for these after every stop and after every idle trigger pulse.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_CONVERT,
        ST_GAP
    } seq_state_e;

    localparam logic [2:0] TM_INT_ONCE   = 3'd0;
    localparam logic [2:0] TM_EXT_ONCE   = 3'd1;
    localparam logic [2:0] TM_INT_REPEAT = 3'd2;
    localparam logic [2:0] TM_EXT_REPEAT = 3'd3;
    localparam logic [2:0] TM_EXT_EACH   = 3'd4;

    localparam logic [2:0] CFG_SCAN_LEN  = 3'd0;
    localparam logic [2:0] CFG_CONV_PRE  = 3'd1;
    localparam logic [2:0] CFG_CONV_DIV  = 3'd2;
    localparam logic [2:0] CFG_SCAN_PRE  = 3'd3;
    localparam logic [2:0] CFG_SCAN_DIV  = 3'd4;
    localparam logic [2:0] CFG_MODE      = 3'd5;
    localparam logic [2:0] CFG_INPUT     = 3'd6;

    localparam int unsigned CHAN_W = 6;
    localparam int unsigned GAIN_W = 2;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [CHAN_W-1:0] chan;
    } list_entry_t;

endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
    parameter int unsigned BASE_CYC = 2,
    parameter int unsigned PRE_W    = 4,
    parameter int unsigned DIV_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    input  logic [DIV_W-1:0] divider,
    output logic             tick
);
    logic             base_wrap;
    logic             pre_wrap;
    logic             div_wrap;
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_end;

    generate
        if (BASE_CYC > 1) begin : g_base
            localparam int unsigned BW = $clog2(BASE_CYC);
            logic [BW-1:0] base_cnt;

            assign base_wrap = (base_cnt == BW'(BASE_CYC - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    base_cnt <= '0;
                end else if (load) begin
                    base_cnt <= '0;
                end else if (run) begin
                    base_cnt <= base_wrap ? '0 : base_cnt + BW'(1);
                end
            end
        end else begin : g_nobase
            assign base_wrap = 1'b1;
        end
    endgenerate

    // divider 0 wraps to all ones: 65536 steps
    assign div_end  = divider - DIV_W'(1);
    assign pre_wrap = (pre_cnt == prescale);
    assign div_wrap = (div_cnt == div_end);
    assign tick     = run & base_wrap & pre_wrap & div_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (load) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (run && base_wrap) begin
            if (pre_wrap) begin
                pre_cnt <= '0;
                div_cnt <= div_wrap ? '0 : div_cnt + DIV_W'(1);
            end else begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
        end
    end

    generate
        if (BASE_CYC > 1) begin : g_gap_chk
            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/chan_list.sv
module chan_list
    import pacer_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        we,
    input  logic [AW-1:0] waddr,
    input  list_entry_t wdata,
    input  logic [AW-1:0] raddr,
    output list_entry_t rdata
);
    list_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pace_seq.sv
module pace_seq
    import pacer_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned LEN_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              ext_trig,
    input  logic [2:0]        mode,
    input  logic [LEN_W-1:0]  len_eff,
    input  logic              conv_tick,
    input  logic              scan_tick,
    input  list_entry_t       rd_entry,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              conv_load,
    output logic              conv_run,
    output logic              scan_load,
    output logic              scan_run,
    output logic              conv_strobe,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [GAIN_W-1:0] conv_gain,
    output logic              scan_done,
    output logic              overrun
);
    seq_state_e       state;
    seq_state_e       state_nx;
    seq_state_e       after_scan;
    logic [LEN_W-1:0] cur_idx;
    logic             periodic;
    logic             ext_mode;
    logic             begin_scan;
    logic             conv_issue;
    logic             issue;
    logic             is_last;
    logic             ovr_set;

    assign periodic = (mode == TM_INT_REPEAT) || (mode == TM_EXT_REPEAT);
    assign ext_mode = (mode == TM_EXT_ONCE) || (mode == TM_EXT_REPEAT) ||
                      (mode == TM_EXT_EACH);

    always_comb begin
        if (periodic) begin
            after_scan = ST_GAP;
        end else if (mode == TM_EXT_EACH) begin
            after_scan = ST_ARMED;
        end else begin
            after_scan = ST_IDLE;
        end
    end

    always_comb begin
        state_nx   = state;
        begin_scan = 1'b0;
        conv_issue = 1'b0;
        scan_load  = 1'b0;
        ovr_set    = 1'b0;
        if (stop) begin
            state_nx = ST_IDLE;
        end else if (start) begin
            case (mode)
                TM_INT_REPEAT: begin
                    begin_scan = 1'b1;
                    scan_load  = 1'b1;
                end
                TM_EXT_ONCE, TM_EXT_REPEAT, TM_EXT_EACH: begin
                    state_nx = ST_ARMED;
                end
                default: begin
                    begin_scan = 1'b1;
                end
            endcase
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nx = ST_IDLE;
                end
                ST_ARMED: begin
                    if (ext_trig && ext_mode) begin
                        begin_scan = 1'b1;
                        scan_load  = (mode == TM_EXT_REPEAT);
                    end
                end
                ST_CONVERT: begin
                    conv_issue = conv_tick;
                    if ((periodic && scan_tick) ||
                        ((mode == TM_EXT_EACH) && ext_trig)) begin
                        ovr_set = 1'b1;
                    end
                end
                ST_GAP: begin
                    if (scan_tick) begin
                        begin_scan = 1'b1;
                    end
                end
            endcase
        end
        issue   = begin_scan | conv_issue;
        is_last = begin_scan ? (len_eff == LEN_W'(1))
                             : (cur_idx == len_eff - LEN_W'(1));
        if (begin_scan) begin
            state_nx = ST_CONVERT;
        end
        if (issue && is_last) begin
            state_nx = after_scan;
        end
    end

    assign rd_idx    = begin_scan ? '0 : cur_idx[IDX_W-1:0];
    assign conv_load = begin_scan;
    assign conv_run  = (state == ST_CONVERT);
    assign scan_run  = periodic && ((state == ST_CONVERT) || (state == ST_GAP));

    // state register and list position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
        end else begin
            state <= state_nx;
            if (begin_scan) begin
                cur_idx <= LEN_W'(1);
            end else if (conv_issue) begin
                cur_idx <= cur_idx + LEN_W'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_strobe <= 1'b0;
            conv_chan   <= '0;
            conv_gain   <= '0;
            scan_done   <= 1'b0;
            overrun     <= 1'b0;
        end else begin
            conv_strobe <= issue;
            scan_done   <= issue && is_last;
            if (issue) begin
                conv_chan <= rd_entry.chan;
                conv_gain <= rd_entry.gain;
            end
            if (start && !stop) begin
                overrun <= 1'b0;
            end else if (ovr_set) begin
                overrun <= 1'b1;
            end
        end
    end

    // R5
    done_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> conv_strobe);

    // R11
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!conv_strobe && !scan_done));

    // R10
    overrun_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(state) == ST_CONVERT));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !start) |=> !conv_strobe);

endmodule

// File: rtl/acq_pacer.sv
module acq_pacer
    import pacer_pkg::*;
#(
    parameter int unsigned LIST_DEPTH    = 512,
    parameter int unsigned CONV_BASE_CYC = 2,
    parameter int unsigned SCAN_BASE_CYC = 4,
    parameter int unsigned PRE_W         = 4,
    parameter int unsigned DIV_W         = 16,
    localparam int unsigned IDX_W        = $clog2(LIST_DEPTH),
    localparam int unsigned LEN_W        = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              list_we,
    input  logic [IDX_W-1:0]  list_addr,
    input  logic [7:0]        list_wdata,
    input  logic              start,
    input  logic              stop,
    input  logic              ext_trig,
    output logic              conv_strobe,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [GAIN_W-1:0] conv_gain,
    output logic              conv_diff,
    output logic              scan_done,
    output logic              overrun
);
    logic [15:0]      scan_len_q;
    logic [PRE_W-1:0] conv_pre_q;
    logic [DIV_W-1:0] conv_div_q;
    logic [PRE_W-1:0] scan_pre_q;
    logic [DIV_W-1:0] scan_div_q;
    logic [2:0]       mode_q;
    logic             diff_q;
    logic [LEN_W-1:0] len_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_len_q <= 16'd1;
            conv_pre_q <= '0;
            conv_div_q <= DIV_W'(1);
            scan_pre_q <= '0;
            scan_div_q <= DIV_W'(1);
            mode_q     <= TM_INT_ONCE;
            diff_q     <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_addr)
                CFG_SCAN_LEN: scan_len_q <= cfg_wdata;
                CFG_CONV_PRE: conv_pre_q <= cfg_wdata[PRE_W-1:0];
                CFG_CONV_DIV: conv_div_q <= cfg_wdata[DIV_W-1:0];
                CFG_SCAN_PRE: scan_pre_q <= cfg_wdata[PRE_W-1:0];
                CFG_SCAN_DIV: scan_div_q <= cfg_wdata[DIV_W-1:0];
                CFG_MODE:     mode_q     <= cfg_wdata[4:2];
                CFG_INPUT:    diff_q     <= cfg_wdata[0];
                default:      diff_q     <= diff_q;
            endcase
        end
    end

    always_comb begin
        if (scan_len_q == 16'd0) begin
            len_eff = LEN_W'(1);
        end else if (scan_len_q > 16'(LIST_DEPTH)) begin
            len_eff = LEN_W'(LIST_DEPTH);
        end else begin
            len_eff = scan_len_q[LEN_W-1:0];
        end
    end

    assign conv_diff = diff_q;

    logic             conv_load;
    logic             conv_run;
    logic             conv_tick;
    logic             scan_load;
    logic             scan_run;
    logic             scan_tick;
    logic [IDX_W-1:0] rd_idx;
    list_entry_t      rd_entry;

    pace_timer #(
        .BASE_CYC (CONV_BASE_CYC),
        .PRE_W    (PRE_W),
        .DIV_W    (DIV_W)
    ) u_conv_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (conv_load),
        .run      (conv_run),
        .prescale (conv_pre_q),
        .divider  (conv_div_q),
        .tick     (conv_tick)
    );

    pace_timer #(
        .BASE_CYC (SCAN_BASE_CYC),
        .PRE_W    (PRE_W),
        .DIV_W    (DIV_W)
    ) u_scan_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (scan_load),
        .run      (scan_run),
        .prescale (scan_pre_q),
        .divider  (scan_div_q),
        .tick     (scan_tick)
    );

    chan_list #(
        .DEPTH (LIST_DEPTH)
    ) u_list (
        .clk   (clk),
        .we    (list_we),
        .waddr (list_addr),
        .wdata (list_entry_t'(list_wdata)),
        .raddr (rd_idx),
        .rdata (rd_entry)
    );

    pace_seq #(
        .DEPTH (LIST_DEPTH)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .stop        (stop),
        .ext_trig    (ext_trig),
        .mode        (mode_q),
        .len_eff     (len_eff),
        .conv_tick   (conv_tick),
        .scan_tick   (scan_tick),
        .rd_entry    (rd_entry),
        .rd_idx      (rd_idx),
        .conv_load   (conv_load),
        .conv_run    (conv_run),
        .scan_load   (scan_load),
        .scan_run    (scan_run),
        .conv_strobe (conv_strobe),
        .conv_chan   (conv_chan),
        .conv_gain   (conv_gain),
        .scan_done   (scan_done),
        .overrun     (overrun)
    );

endmodule

// File: tb/sim_acq_pacer.sv
module sim_acq_pacer;
    localparam int CB = 2;
    localparam int SB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic       list_we = 1'b0;
    logic [8:0] list_addr = '0;
    logic [7:0] list_wdata = '0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic       ext_trig = 1'b0;
    logic       conv_strobe;
    logic [5:0] conv_chan;
    logic [1:0] conv_gain;
    logic       conv_diff;
    logic       scan_done;
    logic       overrun;

    acq_pacer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .list_we(list_we), .list_addr(list_addr),
        .list_wdata(list_wdata), .start(start), .stop(stop), .ext_trig(ext_trig),
        .conv_strobe(conv_strobe), .conv_chan(conv_chan), .conv_gain(conv_gain),
        .conv_diff(conv_diff), .scan_done(scan_done), .overrun(overrun)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_vec = 0;
    int n_bad = 0;
    int n_st = 0;
    int lg_cyc [0:1023];
    int lg_ent [0:1023];
    bit lg_done [0:1023];
    logic [7:0] lst [0:511];

    always @(negedge clk) begin
        if (rst_n && conv_strobe) begin
            if (n_st < 1024) begin
                lg_cyc[n_st]  = cyc;
                lg_ent[n_st]  = int'({conv_gain, conv_chan});
                lg_done[n_st] = scan_done;
            end
            n_st = n_st + 1;
        end
    end

    function automatic int tper(int base, int pre, int dv);
        return base * (pre + 1) * ((dv == 0) ? 65536 : dv);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [2:0] a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_list(input int len);
        for (int i = 0; i < len; i++) begin
            lst[i] = 8'($urandom);
            @(negedge clk);
            list_we = 1'b1; list_addr = 9'(i); list_wdata = lst[i];
        end
        @(negedge clk);
        list_we = 1'b0;
    endtask

    task automatic do_start(output int at);
        @(negedge clk);
        start = 1'b1; at = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic do_ext(output int at);
        @(negedge clk);
        ext_trig = 1'b1; at = cyc;
        @(negedge clk);
        ext_trig = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic set_timers(input int cp, input int cd, input int sp, input int sd);
        wr_cfg(3'd1, cp); wr_cfg(3'd2, cd); wr_cfg(3'd3, sp); wr_cfg(3'd4, sd);
    endtask

    task automatic expect_scan(input int org, input int m, input int len, input int pc,
                               input int ps, input int first, input string req);
        for (int k = 0; k < len; k++) begin
            int idx = first + k;
            int ec = org + 1 + m * ps + k * pc;
            int ee = int'(lst[k]);
            bit ed = (k == len - 1);
            bit have = (idx < n_st) && (idx < 1024);
            int ac = have ? lg_cyc[idx] : -1;
            int ae = have ? lg_ent[idx] : -1;
            bit ad = have ? lg_done[idx] : 1'b0;
            n_vec++;
            if (!(have && ac == ec && ae == ee && ad == ed)) begin
                n_bad++;
                $display("FAIL %s strobe %0d: actual cyc %0d entry %0d done %0d expected cyc %0d entry %0d done %0d",
                         req, idx, ac, ae, ad, ec, ee, ed);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual cycle %0d expected completion earlier", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int at, at2, at3, len, cp, cd, pc, sp, sd, ps, base;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!conv_strobe && !scan_done && !overrun && conv_chan == 0 && conv_gain == 0,
              "R1", "outputs idle", int'({conv_strobe, scan_done, overrun}), 0);
        repeat (10) @(negedge clk);
        check(n_st == 0, "R1", "no strobe before start", n_st, 0);

        // R12 input type bit
        wr_cfg(3'd6, 1);
        @(negedge clk);
        check(conv_diff == 1'b1, "R12", "diff set", int'(conv_diff), 1);
        wr_cfg(3'd6, 16'hfffe);
        @(negedge clk);
        check(conv_diff == 1'b0, "R12", "diff clear", int'(conv_diff), 0);

        // R2 R4 R5 R6: random one-shot scans
        for (int it = 0; it < 5; it++) begin
            len = 1 + int'($urandom % 6);
            cp = int'($urandom % 3);
            cd = 1 + int'($urandom % 5);
            pc = tper(CB, cp, cd);
            load_list(len);
            set_timers(cp, cd, 0, 1);
            wr_cfg(3'd0, len);
            wr_cfg(3'd5, ((it == 4) ? 7 : 0) << 2);
            n_st = 0;
            do_start(at);
            wait_until(at + 1 + len * pc + 5);
            check(n_st == len, "R5", "strobe count one-shot", n_st, len);
            expect_scan(at, 0, len, pc, 0, 0, (it == 4) ? "R6" : "R4");
        end

        // R13 ext trigger after one-shot is ignored
        n_st = 0;
        do_ext(at);
        repeat (40) @(negedge clk);
        check(n_st == 0, "R13", "ext_trig when idle", n_st, 0);

        // R11 stop in the middle of a scan
        len = 5;
        load_list(len);
        set_timers(0, 5, 0, 1);
        wr_cfg(3'd0, len);
        wr_cfg(3'd5, 0);
        n_st = 0;
        do_start(at);
        wait_until(at + 21);
        do_stop();
        repeat (80) @(negedge clk);
        check(n_st == 3, "R11", "strobes after mid-scan stop", n_st, 3);
        check(n_st >= 3 && !lg_done[0] && !lg_done[1] && !lg_done[2], "R11",
              "no scan_done after stop", 0, 0);

        // R3 R7: internally repeating scans
        len = 3;
        cp = int'($urandom % 2);
        cd = 1 + int'($urandom % 4);
        pc = tper(CB, cp, cd);
        sp = int'($urandom % 2);
        sd = (pc * len) / (SB * (sp + 1)) + 2 + int'($urandom % 3);
        ps = tper(SB, sp, sd);
        load_list(len);
        set_timers(cp, cd, sp, sd);
        wr_cfg(3'd0, len);
        wr_cfg(3'd5, 2 << 2);
        n_st = 0;
        do_start(at);
        wait_until(at + 2 + 2 * ps + (len - 1) * pc);
        do_stop();
        for (int m = 0; m < 3; m++) expect_scan(at, m, len, pc, ps, m * len, (m == 0) ? "R7" : "R3");
        base = n_st;
        repeat (2 * ps) @(negedge clk);
        check(n_st == 3 * len, "R11", "no strobe after stop", n_st, 3 * len);
        check(base == n_st, "R7", "count stable", n_st, base);

        // R8 R13: externally triggered one-shot
        len = 4;
        load_list(len);
        set_timers(1, 2, 0, 1);
        pc = tper(CB, 1, 2);
        wr_cfg(3'd0, len);
        wr_cfg(3'd5, 1 << 2);
        n_st = 0;
        do_ext(at);
        repeat (30) @(negedge clk);
        check(n_st == 0, "R13", "ext_trig before start", n_st, 0);
        do_start(at);
        repeat (40) @(negedge clk);
        check(n_st == 0, "R8", "armed waits for trigger", n_st, 0);
        do_ext(at);
        wait_until(at + 1 + len * pc + 3);
        expect_scan(at, 0, len, pc, 0, 0, "R8");
        do_ext(at2);
        repeat (60) @(negedge clk);
        check(n_st == len, "R13", "trigger after one-shot", n_st, len);

        // R8: externally started repeating scans
        len = 2;
        load_list(len);
        pc = tper(CB, 0, 3);
        sd = 4;
        ps = tper(SB, 0, sd);
        set_timers(0, 3, 0, sd);
        wr_cfg(3'd0, len);
        wr_cfg(3'd5, 3 << 2);
        n_st = 0;
        do_start(at);
        repeat (25) @(negedge clk);
        do_ext(at);
        wait_until(at + 2 + ps + (len - 1) * pc);
        do_stop();
        expect_scan(at, 0, len, pc, ps, 0, "R8");
        expect_scan(at, 1, len, pc, ps, len, "R8");
        check(n_st == 2 * len, "R8", "repeat count", n_st, 2 * len);

        // R9: one scan per trigger, overrun on trigger during scan
        len = 3;
        load_list(len);
        pc = tper(CB, 0, 3);
        set_timers(0, 3, 0, 1);
        wr_cfg(3'd0, len);
        wr_cfg(3'd5, 4 << 2);
        n_st = 0;
        do_start(at);
        do_ext(at);
        wait_until(at + 1 + len * pc + 3);
        expect_scan(at, 0, len, pc, 0, 0, "R9");
        check(overrun == 1'b0, "R9", "no overrun yet", int'(overrun), 0);
        do_ext(at2);
        wait_until(at2 + 1 + pc);
        do_ext(at3);
        wait_until(at2 + 1 + len * pc + 3);
        check(overrun == 1'b1, "R9", "overrun on trigger in scan", int'(overrun), 1);
        expect_scan(at2, 0, len, pc, 0, len, "R9");
        check(n_st == 2 * len, "R9", "no restart", n_st, 2 * len);
        do_ext(at);
        wait_until(at + 1 + len * pc + 3);
        expect_scan(at, 0, len, pc, 0, 2 * len, "R9");
        do_stop();

        // R10: scan tick during a scan
        len = 4;
        load_list(len);
        set_timers(0, 5, 0, 5);
        pc = 10; ps = 20;
        wr_cfg(3'd0, len);
        wr_cfg(3'd5, 2 << 2);
        n_st = 0;
        do_start(at);
        check(overrun == 1'b0, "R10", "cleared by start", int'(overrun), 0);
        wait_until(at + 25);
        check(overrun == 1'b1, "R10", "overrun set", int'(overrun), 1);
        wait_until(at + 75);
        do_stop();
        expect_scan(at, 0, len, pc, ps, 0, "R10");
        expect_scan(at, 2, len, pc, ps, len, "R10");
        check(n_st == 2 * len, "R10", "dropped tick", n_st, 2 * len);
        wr_cfg(3'd5, 0);
        do_start(at);
        check(overrun == 1'b0, "R10", "start clears overrun", int'(overrun), 0);
        repeat (20) @(negedge clk);

        // R5: length 0 acts as 1
        set_timers(0, 1, 0, 1);
        wr_cfg(3'd0, 0);
        n_st = 0;
        do_start(at);
        repeat (20) @(negedge clk);
        check(n_st == 1, "R5", "length zero", n_st, 1);
        expect_scan(at, 0, 1, 2, 0, 0, "R5");

        // R5: length above depth clamps to 512
        load_list(512);
        wr_cfg(3'd0, 600);
        n_st = 0;
        do_start(at);
        wait_until(at + 1 + 512 * 2 + 10);
        check(n_st == 512, "R5", "clamped length", n_st, 512);
        expect_scan(at, 0, 512, 2, 0, 0, "R5");

        // R2: divider zero is 65536
        load_list(2);
        set_timers(0, 0, 0, 1);
        wr_cfg(3'd0, 2);
        pc = tper(CB, 0, 0);
        n_st = 0;
        do_start(at);
        wait_until(at + 1 + pc + 3);
        expect_scan(at, 0, 2, pc, 0, 0, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule